// File: doc/BRIEF.md
# Memory Parity Error Capture Unit

This block sits beside a 32-bit memory data path made of four byte lanes. On every write it computes one odd-parity bit per byte lane. It stores these bits in a small side array, indexed by word address, and updates only the lanes whose write strobes are set. A test control can make it store inverted parity instead, so that software can plant known-bad words and exercise its error handlers.

On every read with checking enabled, the block recomputes parity on the returned data and compares it with the stored bits. The first failing read freezes a snapshot and raises a held interrupt request. The snapshot holds the failing lanes, the virtual address, the context number and the bus-master source of the access. Later failures leave the snapshot alone. Software reads the snapshot through two 32-bit registers on a simple register bus, a status/control word and a captured-address word. Software releases the snapshot only by writing the most significant byte of the captured-address word.

Top module: `mem_parity_guard`

## Requirements
- R1: A memory write stores, for each lane whose strobe `mem_be[i]` is 1, a parity bit that makes the count of ones over that byte and the bit odd. Lanes whose strobe is 0 keep their previously stored bit.
- R2: While the test control (status word bit 5) is 1, writes store the inverse of the odd-parity bit. A later read of the same data with the test control at 0 therefore flags every lane that was written this way.
- R3: A read with checking enabled (status word bit 4) flags lane i when the returned byte `mem_rdata[8i+7:8i]` and the stored bit have an even count of ones. The lane flags appear in status word bits 3:0, with bit i for lane i.
- R4: The first failing read sets the pending flag (status bit 7). In the same cycle it records the failing lanes, the virtual address (address word), the context number (status bits 16:9) and the source (status bit 8, 1 when the access came from DVMA). All of these are readable after one clock edge.
- R5: While pending is set, further failing reads do not change the lane flags, the captured address, the context or the source bit.
- R6: A register write to the address word (`reg_addr`=1) with `reg_be[3]`=1 clears pending, the lane flags and all captured fields. A write to that word with `reg_be[3]`=0 has no effect.
- R7: `irq_out` is 1 exactly when pending is 1 and the interrupt enable (status bit 6) is 1.
- R8: A read with checking disabled never sets a lane flag or the pending flag.
- R9: After reset, both registers read as zero and `irq_out` is 0.
- R10: When a clearing write and a failing checked read fall in the same cycle, the new failure is captured. The old snapshot is replaced and pending stays set.
- R11: A write to the status word (`reg_addr`=0) with `reg_be[0]`=1 loads bits 6:4 from `reg_wdata[6:4]`. All other status bits ignore the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_wr | input | 1 | Memory write cycle |
| mem_rd | input | 1 | Memory read cycle, returned data valid on `mem_rdata` |
| mem_word_addr | input | 4 | Word index into the parity side array |
| mem_be | input | 4 | Byte-lane write strobes |
| mem_wdata | input | 32 | Write data |
| mem_rdata | input | 32 | Read data returned by the memory |
| mem_vaddr | input | 32 | Virtual address of the current cycle |
| mem_ctx | input | 8 | Context number of the current cycle |
| mem_dvma | input | 1 | 1 when the cycle comes from DVMA, 0 for the CPU |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 status/control, 1 captured address |
| reg_be | input | 4 | Register byte enables |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq_out | output | 1 | Held interrupt request |

## Verification
A clearing write to the top byte of the address word and a failing checked read can land on the same clock edge. The bench provokes this by driving both in one cycle while an older snapshot is frozen. It then checks that the status word and the address word show the newer failure's lanes, context and address, with pending still set. The bench also pairs a frozen snapshot with a second failing read, and a lower-byte-only write with a pending snapshot. In both cases it judges, through register reads, that nothing captured has moved.

// File: rtl/mpg_pkg.sv
package mpg_pkg;
  localparam int LANES   = 4;
  localparam int LANE_W  = 8;
  localparam int DATA_W  = LANES * LANE_W;
  localparam int CTX_W   = 8;
  // status word field positions (software-visible layout)
  localparam int B_CHECK = 4;
  localparam int B_TEST  = 5;
  localparam int B_INTEN = 6;
  localparam int B_PEND  = 7;
  localparam int B_DVMA  = 8;
  localparam int CTX_LSB = 9;

  typedef struct packed {
    logic inten;
    logic test;
    logic check;
  } ctl_t;
endpackage

// File: rtl/mpg_parity_lanes.sv
module mpg_parity_lanes #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [LANES*LANE_W-1:0] rdata,
  input  logic                    test_inv,
  input  logic [LANES-1:0]        stored,
  output logic [LANES-1:0]        wr_par,
  output logic [LANES-1:0]        mismatch
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic wr_xor, rd_xor;
    assign wr_xor      = ^wdata[i*LANE_W +: LANE_W];
    assign rd_xor      = ^rdata[i*LANE_W +: LANE_W];
    // odd parity: bit = inverse of data xor; test mode flips it again
    assign wr_par[i]   = ~wr_xor ^ test_inv;
    // good word: data xor plus stored bit is odd
    assign mismatch[i] = ~(rd_xor ^ stored[i]);
  end

  always_comb begin
    assert (test_inv || ((^wdata[LANE_W-1:0]) ^ wr_par[0]))
      else $error("p_odd_lane0_r1 violated");
  end
endmodule

// File: rtl/mpg_side_array.sv
module mpg_side_array #(
  parameter int LANES  = 4,
  parameter int WORD_AW = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [WORD_AW-1:0] wr_addr,
  input  logic [LANES-1:0]   wr_be,
  input  logic [LANES-1:0]   wr_par,
  input  logic [WORD_AW-1:0] rd_addr,
  output logic [LANES-1:0]   rd_par
);
  localparam int DEPTH = 1 << WORD_AW;

  logic [DEPTH-1:0][LANES-1:0] mem_q, mem_d;

  always_comb begin
    mem_d = mem_q;
    for (int i = 0; i < LANES; i++) begin
      if (wr_be[i]) mem_d[wr_addr][i] = wr_par[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mem_q <= '0;
    else if (wr_en) mem_q <= mem_d;
  end

  assign rd_par = mem_q[rd_addr];

  p_unstrobed_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_be[0]) |=> (mem_q[$past(wr_addr)][0] == $past(mem_q[wr_addr][0])));

  p_strobed_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_be[LANES-1]) |=> (mem_q[$past(wr_addr)][LANES-1] == $past(wr_par[LANES-1])));
endmodule

// File: rtl/mpg_err_capture.sv
module mpg_err_capture #(
  parameter int LANES  = 4,
  parameter int ADDR_W = 32,
  parameter int CTX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  input  logic              check_en,
  input  logic [LANES-1:0]  mismatch,
  input  logic              clr,
  input  logic [ADDR_W-1:0] cyc_vaddr,
  input  logic [CTX_W-1:0]  cyc_ctx,
  input  logic              cyc_dvma,
  output logic              pending,
  output logic [LANES-1:0]  flags,
  output logic [ADDR_W-1:0] cap_vaddr,
  output logic [CTX_W-1:0]  cap_ctx,
  output logic              cap_dvma
);
  logic              hit, take, ld_en;
  logic              pend_d;
  logic [LANES-1:0]  flags_d;
  logic [ADDR_W-1:0] va_d;
  logic [CTX_W-1:0]  ctx_d;
  logic              dvma_d;

  assign hit   = rd_valid & check_en & (|mismatch);
  // a clear in the same cycle re-opens the snapshot for the new failure
  assign take  = hit & (~pending | clr);
  assign ld_en = take | clr;

  always_comb begin
    if (take) begin
      pend_d  = 1'b1;
      flags_d = mismatch;
      va_d    = cyc_vaddr;
      ctx_d   = cyc_ctx;
      dvma_d  = cyc_dvma;
    end else begin
      pend_d  = 1'b0;
      flags_d = '0;
      va_d    = '0;
      ctx_d   = '0;
      dvma_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending   <= 1'b0;
      flags     <= '0;
      cap_vaddr <= '0;
      cap_ctx   <= '0;
      cap_dvma  <= 1'b0;
    end else if (ld_en) begin
      pending   <= pend_d;
      flags     <= flags_d;
      cap_vaddr <= va_d;
      cap_ctx   <= ctx_d;
      cap_dvma  <= dvma_d;
    end
  end

  p_first_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && check_en && (mismatch != '0)) |=> pending);

  p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !clr) |=> ($stable(flags) && $stable(cap_vaddr) && $stable(cap_ctx) && $stable(cap_dvma) && pending));

  p_nocheck_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!check_en && !clr) |=> ($stable(pending) && $stable(flags)));

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !(rd_valid && check_en && (mismatch != '0))) |=> (!pending && flags == '0));

  p_pend_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> (flags != '0));

  p_same_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && rd_valid && check_en && (mismatch != '0)) |=> (pending && flags == $past(mismatch)));
endmodule

// File: rtl/mpg_regbank.sv
module mpg_regbank
  import mpg_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int ADDR_W = 32,
  parameter int CTX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [3:0]        reg_be,
  input  logic [31:0]       reg_wdata,
  input  logic              pending,
  input  logic [LANES-1:0]  flags,
  input  logic [ADDR_W-1:0] cap_vaddr,
  input  logic [CTX_W-1:0]  cap_ctx,
  input  logic              cap_dvma,
  output ctl_t              ctl,
  output logic              clr,
  output logic [31:0]       reg_rdata
);
  logic ctl_we;
  ctl_t ctl_d;

  assign ctl_we = reg_wr & ~reg_addr & reg_be[0];
  assign clr    = reg_wr &  reg_addr & reg_be[3];

  always_comb begin
    ctl_d       = ctl;
    ctl_d.check = reg_wdata[B_CHECK];
    ctl_d.test  = reg_wdata[B_TEST];
    ctl_d.inten = reg_wdata[B_INTEN];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl <= '0;
    else if (ctl_we) ctl <= ctl_d;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr) begin
      reg_rdata = 32'(cap_vaddr);
    end else begin
      reg_rdata[LANES-1:0]              = flags;
      reg_rdata[B_CHECK]                = ctl.check;
      reg_rdata[B_TEST]                 = ctl.test;
      reg_rdata[B_INTEN]                = ctl.inten;
      reg_rdata[B_PEND]                 = pending;
      reg_rdata[B_DVMA]                 = cap_dvma;
      reg_rdata[CTX_LSB +: CTX_W]       = cap_ctx;
    end
  end

  p_ctl_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && !reg_addr && reg_be[0]) |=> $stable(ctl));
endmodule

// File: rtl/mem_parity_guard.sv
module mem_parity_guard
  import mpg_pkg::*;
#(
  parameter int WORD_AW = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mem_wr,
  input  logic               mem_rd,
  input  logic [WORD_AW-1:0] mem_word_addr,
  input  logic [LANES-1:0]   mem_be,
  input  logic [DATA_W-1:0]  mem_wdata,
  input  logic [DATA_W-1:0]  mem_rdata,
  input  logic [31:0]        mem_vaddr,
  input  logic [CTX_W-1:0]   mem_ctx,
  input  logic               mem_dvma,
  input  logic               reg_wr,
  input  logic               reg_addr,
  input  logic [3:0]         reg_be,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               irq_out
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  ctl_t             ctl;
  logic             clr;
  logic [LANES-1:0] wr_par, stored, mismatch;
  logic             pending, cap_dvma;
  logic [LANES-1:0] flags;
  logic [31:0]      cap_vaddr;
  logic [CTX_W-1:0] cap_ctx;

  mpg_parity_lanes #(.LANES(LANES), .LANE_W(LANE_W)) u_lanes (
    .wdata    (mem_wdata),
    .rdata    (mem_rdata),
    .test_inv (ctl.test),
    .stored   (stored),
    .wr_par   (wr_par),
    .mismatch (mismatch)
  );

  mpg_side_array #(.LANES(LANES), .WORD_AW(WORD_AW)) u_array (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_en   (mem_wr),
    .wr_addr (mem_word_addr),
    .wr_be   (mem_be),
    .wr_par  (wr_par),
    .rd_addr (mem_word_addr),
    .rd_par  (stored)
  );

  mpg_err_capture #(.LANES(LANES), .ADDR_W(32), .CTX_W(CTX_W)) u_capture (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .rd_valid  (mem_rd & ~mem_wr),
    .check_en  (ctl.check),
    .mismatch  (mismatch),
    .clr       (clr),
    .cyc_vaddr (mem_vaddr),
    .cyc_ctx   (mem_ctx),
    .cyc_dvma  (mem_dvma),
    .pending   (pending),
    .flags     (flags),
    .cap_vaddr (cap_vaddr),
    .cap_ctx   (cap_ctx),
    .cap_dvma  (cap_dvma)
  );

  mpg_regbank #(.LANES(LANES), .ADDR_W(32), .CTX_W(CTX_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_be    (reg_be),
    .reg_wdata (reg_wdata),
    .pending   (pending),
    .flags     (flags),
    .cap_vaddr (cap_vaddr),
    .cap_ctx   (cap_ctx),
    .cap_dvma  (cap_dvma),
    .ctl       (ctl),
    .clr       (clr),
    .reg_rdata (reg_rdata)
  );

  assign irq_out = pending & ctl.inten;

  p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    !ctl.inten |-> !irq_out);

  p_irq_held_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (irq_out && !clr && !(reg_wr && !reg_addr && reg_be[0])) |=> irq_out);
endmodule

// File: tb/mem_parity_guard_tb.sv
module mem_parity_guard_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_wr = 0, mem_rd = 0, mem_dvma = 0;
  logic [3:0]  mem_word_addr = '0, mem_be = '0;
  logic [31:0] mem_wdata = '0, mem_rdata = '0, mem_vaddr = '0;
  logic [7:0]  mem_ctx = '0;
  logic        reg_wr = 0, reg_addr = 0;
  logic [3:0]  reg_be = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk; // 50 MHz

  mem_parity_guard dut_i (
    .clk(clk), .rst_n(rst_n), .mem_wr(mem_wr), .mem_rd(mem_rd),
    .mem_word_addr(mem_word_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_vaddr(mem_vaddr), .mem_ctx(mem_ctx),
    .mem_dvma(mem_dvma), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_be(reg_be),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  function automatic logic [31:0] word_data(int w);
    return (32'(w + 1) * 32'h1357_9BDF) ^ 32'hA5C3_0F96;
  endfunction

  function automatic logic [31:0] flip_of(logic [3:0] m);
    logic [31:0] f = '0;
    for (int i = 0; i < 4; i++) if (m[i]) f[8*i] = 1'b1;
    return f;
  endfunction

  function automatic logic [31:0] stat_word(logic [3:0] fl, logic [2:0] en,
                                            logic pend, logic dv, logic [7:0] cx);
    return (32'(cx) << 9) | (32'(dv) << 8) | (32'(pend) << 7) | (32'(en) << 4) | 32'(fl);
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic rd_reg(logic a, output logic [31:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wr_reg(logic a, logic [3:0] be, logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_be = be; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_be = '0;
  endtask

  task automatic mem_write(int w, logic [31:0] d, logic [3:0] be);
    mem_wr = 1; mem_word_addr = 4'(w); mem_wdata = d; mem_be = be;
    @(negedge clk);
    mem_wr = 0; mem_be = '0;
  endtask

  task automatic mem_read(int w, logic [31:0] d, logic [31:0] va, logic [7:0] cx, logic dv);
    mem_rd = 1; mem_word_addr = 4'(w); mem_rdata = d;
    mem_vaddr = va; mem_ctx = cx; mem_dvma = dv;
    @(negedge clk);
    mem_rd = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v, va;
    logic [31:0] a8, a_hi;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R9 reset state
    rd_reg(0, v); chk("R9 status", v, 32'h0);
    rd_reg(1, v); chk("R9 address", v, 32'h0);
    chk("R9 irq", 32'(irq_out), 32'h0);

    // R11 only bits 6:4 take written data
    wr_reg(0, 4'hF, 32'hFFFF_FFFF);
    rd_reg(0, v); chk("R11 status writable bits", v, 32'h70);
    wr_reg(0, 4'hE, 32'h0);
    rd_reg(0, v); chk("R11 be0 low ignored", v, 32'h70);
    wr_reg(0, 4'h1, 32'h50); // check + inten

    // R1 all words, matching reads never flag
    for (int w = 0; w < 16; w++) mem_write(w, word_data(w), 4'hF);
    for (int w = 0; w < 16; w++) mem_read(w, word_data(w), 32'h0, 8'h0, 1'b0);
    rd_reg(0, v); chk("R1 clean reads", v, 32'h50);

    // R1 strobes: lanes 1,3 keep old parity of 0x00, lanes 0,2 take 0x01
    mem_write(3, 32'h0000_0000, 4'hF);
    mem_write(3, 32'h0101_0101, 4'b0101);
    mem_read(3, 32'h0001_0001, 32'h0, 8'h0, 1'b0);
    rd_reg(0, v); chk("R1 merged word clean", v, 32'h50);
    mem_read(3, 32'h0101_0101, 32'h3C, 8'h33, 1'b1);
    rd_reg(0, v); chk("R1 unstrobed lanes kept", v, stat_word(4'b1010, 3'b101, 1, 1, 8'h33));
    wr_reg(1, 4'h8, 32'h0);

    // R3 R4 sweep every lane pattern
    for (int m = 1; m < 16; m++) begin
      va = 32'h1000_0000 + 32'(m) * 32'h44;
      mem_read(5, word_data(5) ^ flip_of(4'(m)), va, 8'(m * 17), m[0]);
      rd_reg(0, v);
      chk("R3 R4 status capture", v, stat_word(4'(m), 3'b101, 1, m[0], 8'(m * 17)));
      rd_reg(1, v); chk("R4 address capture", v, va);
      chk("R7 irq raised", 32'(irq_out), 32'h1);
      wr_reg(1, 4'h8, 32'h0);
      rd_reg(0, v); chk("R6 cleared", v, 32'h50);
    end

    // R5 frozen snapshot
    mem_read(2, word_data(2) ^ flip_of(4'b0110), 32'hAAAA_0008, 8'h5A, 1'b0);
    mem_read(4, word_data(4) ^ flip_of(4'b1001), 32'hBBBB_0010, 8'hC3, 1'b1);
    rd_reg(0, v); chk("R5 status frozen", v, stat_word(4'b0110, 3'b101, 1, 0, 8'h5A));
    rd_reg(1, v); chk("R5 address frozen", v, 32'hAAAA_0008);

    // R6 lower-byte writes ignored
    wr_reg(1, 4'b0111, 32'hFFFF_FFFF);
    rd_reg(0, v); chk("R6 low write status", v, stat_word(4'b0110, 3'b101, 1, 0, 8'h5A));
    rd_reg(1, v); chk("R6 low write address", v, 32'hAAAA_0008);

    // R7 gating by enable
    wr_reg(0, 4'h1, 32'h10);
    chk("R7 irq masked", 32'(irq_out), 32'h0);
    wr_reg(0, 4'h1, 32'h50);
    chk("R7 irq unmasked", 32'(irq_out), 32'h1);

    // R10 clear and new failure on the same edge
    reg_wr = 1; reg_addr = 1; reg_be = 4'h8; reg_wdata = 32'h0;
    mem_read(6, word_data(6) ^ flip_of(4'b1100), 32'hCCCC_0018, 8'h7E, 1'b1);
    reg_wr = 0; reg_be = '0;
    rd_reg(0, v); chk("R10 new snapshot status", v, stat_word(4'b1100, 3'b101, 1, 1, 8'h7E));
    rd_reg(1, v); chk("R10 new snapshot address", v, 32'hCCCC_0018);
    wr_reg(1, 4'hF, 32'h0);
    rd_reg(1, v); chk("R6 full clear address", v, 32'h0);

    // R8 checking disabled
    wr_reg(0, 4'h1, 32'h40);
    mem_read(7, word_data(7) ^ flip_of(4'hF), 32'h7777_0000, 8'h11, 1'b1);
    rd_reg(0, v); chk("R8 no capture", v, 32'h40);
    chk("R8 irq idle", 32'(irq_out), 32'h0);

    // R2 test mode plants inverted parity
    wr_reg(0, 4'h1, 32'h60);
    mem_write(7, word_data(7), 4'hF);
    wr_reg(0, 4'h1, 32'h50);
    mem_read(7, word_data(7), 32'h0000_7000, 8'h22, 1'b0);
    rd_reg(0, v); chk("R2 all lanes inverted", v, stat_word(4'hF, 3'b101, 1, 0, 8'h22));
    wr_reg(1, 4'h8, 32'h0);
    mem_write(8, word_data(8), 4'hF);
    wr_reg(0, 4'h1, 32'h60);
    mem_write(8, word_data(8), 4'b0010);
    wr_reg(0, 4'h1, 32'h50);
    mem_read(8, word_data(8), 32'h0000_8000, 8'h99, 1'b1);
    rd_reg(0, a8); chk("R2 single lane inverted", a8, stat_word(4'b0010, 3'b101, 1, 1, 8'h99));
    rd_reg(1, a_hi); chk("R2 address", a_hi, 32'h0000_8000);

    finish_run();
  end
endmodule